// File: doc/BRIEF.md
# Prescaled Reloading Down-Count Timer Bank

This block is a bank of identical interval timers for an interrupt controller. A fixed divide-by-DIV prescaler turns the system clock into a timer tick. Each timer holds a base value and a live count. After it is armed, the count steps down by one per tick. A timer with base N spends exactly one tick at each of N, N-1, ..., 0, so its period is N+1 ticks. To get a period of P ticks, software writes P-1.

When the count leaves zero, the timer raises a one-cycle interrupt pulse. The count then either reloads from the base value or wraps to the all-ones value of its width, as the timer's control register selects. A timer can also be set to step once per rollover of the timer below it instead of once per tick. Chained this way, timers build long intervals, and only the last timer in a chain raises its interrupt. A plain register port (address, write data, write enable, registered read data) gives access to every timer.

Top module: `prescaled_timer_bank`

## Requirements
- R1: The timer tick occurs once every DIV (default 8) system clocks. Counters change only on a tick, so base 0 gives an interrupt every 8 clocks.
- R2: The register address is {timer index, 2-bit field}: field 0 is base, field 1 is current count, field 2 is control. Read data appears on the clock after the address is presented. Once a timer is armed with base N, its count reads N and then decreases by exactly one per tick.
- R3: The period between rollovers is (N+1) ticks. Base 0, 1 and 10 give interrupts every 8, 16 and 88 clocks.
- R4: With control bit 0 clear, a count at zero reloads from the base register on the next tick, so the periods stay constant.
- R5: With control bit 0 set, a count at zero wraps to 2^CNT_W-1, so the next interval with default parameters is 4096 ticks (32768 clocks).
- R6: Base register bit 31 is an inhibit. While it is set, the count holds and no interrupt is raised. Writing it to 0 from the inhibited state loads the written base value into the count.
- R7: Writing the base value while the timer runs leaves the current count and the current period untouched. The new value applies from the next reload.
- R8: With control bit 1 set on timer i>0, timer i steps once per rollover of timer i-1 and the interrupt of timer i-1 is suppressed. Control bit 1 has no effect on timer 0.
- R9: Each rollover raises its interrupt for exactly one clock, on the clock after the rollover tick.
- R10: The current count field is read-only. Writes to it change nothing.
- R11: After reset every timer is inhibited with base 0, count 0 and control 0. Interrupts and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | log2(NUM_TMR)+2 | Register address {timer index, field} |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable for addr/wdata |
| rdata | output | DATA_W | Registered read data |
| irq | output | NUM_TMR | One-cycle rollover pulse per timer |

## Verification
A count that is off by one step shows up on irq as an interval one tick (8 clocks) too long or too short. At a small base this appears within tens of clocks. A wrong wrap value only appears one full wrap later. A stuck inhibit, a lost reload or a wrong cascade routing makes an interrupt vanish or appear on the wrong line within one period. A corrupted count field is visible on rdata one clock after it is addressed. The bench's model, compared every clock, catches any such divergence on the first clock in which it reaches irq or rdata.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_COUNT = 2'd1,
    FLD_CTRL  = 2'd2,
    FLD_NONE  = 2'd3
  } field_e;

  typedef struct packed {
    logic cascade;
    logic wrap;
  } ctrl_t;
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                  phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);

  // R1: the phase never leaves its range
  a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R1: ticks are never back to back
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              base_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  base_o,
  output logic              inh_o,
  output ctrl_t             ctrl_o,
  output logic              roll_o
);
  logic [CNT_W-1:0] cnt_q, base_q;
  logic             inh_q;
  ctrl_t            ctrl_q;
  logic             load, step;

  assign load   = base_we_i && inh_q && !wdata_i[DATA_W-1];
  assign step   = en_i && !inh_q;
  assign roll_o = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      base_q <= '0;
      inh_q  <= 1'b1;
      ctrl_q <= '0;
    end else begin
      if (base_we_i) begin
        base_q <= wdata_i[CNT_W-1:0];
        inh_q  <= wdata_i[DATA_W-1];
      end
      if (ctrl_we_i) begin
        ctrl_q.wrap    <= wdata_i[0];
        ctrl_q.cascade <= wdata_i[1];
      end
      if (load)
        cnt_q <= wdata_i[CNT_W-1:0];
      else if (step)
        cnt_q <= (cnt_q == '0) ? (ctrl_q.wrap ? '1 : base_q) : cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign base_o = base_q;
  assign inh_o  = inh_q;
  assign ctrl_o = ctrl_q;

  // R2: a running non-zero count moves down by exactly one per enable
  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4: reload mode restarts from the base held before the edge
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (roll_o && !ctrl_q.wrap) |=> cnt_q == $past(base_q));
  // R5: wrap mode goes to all ones
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (roll_o && ctrl_q.wrap) |=> cnt_q == '1);
  // R6: an inhibited timer holds its count unless armed
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (inh_q && !load) |=> $stable(cnt_q));
  // R7: a base write while idle between steps leaves the count alone
  a_r7_base_quiet: assert property (@(posedge clk) disable iff (rst)
    (base_we_i && !load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/prescaled_timer_bank.sv
module prescaled_timer_bank
  import ptb_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 12,
  parameter int DIV     = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
  localparam int AW     = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               we,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_TMR-1:0] irq
);
  logic                           tick;
  logic [IDX_W-1:0]               idx;
  field_e                         fld;
  logic [NUM_TMR-1:0]             en, roll, inh, fwd;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt, base;
  ctrl_t [NUM_TMR-1:0]            ctrl;
  logic [NUM_TMR-1:0]             irq_q;
  logic [DATA_W-1:0]              rd_next, rdata_q;

  assign idx = addr[AW-1:2];
  assign fld = field_e'(addr[1:0]);

  ptb_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      if (g == 0) begin : g_first
        assign en[g] = tick;
      end else begin : g_chain
        assign en[g] = ctrl[g].cascade ? roll[g-1] : tick;
      end

      if (g == NUM_TMR - 1) begin : g_last
        assign fwd[g] = 1'b0;
      end else begin : g_mid
        assign fwd[g] = ctrl[g+1].cascade;
        // R8: a timer feeding a cascaded neighbour stays silent
        a_r8_upstream_quiet: assert property (@(posedge clk) disable iff (rst)
          ctrl[g+1].cascade |=> !irq_q[g]);
      end

      ptb_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en[g]),
        .base_we_i (we && idx == IDX_W'(g) && fld == FLD_BASE),
        .ctrl_we_i (we && idx == IDX_W'(g) && fld == FLD_CTRL),
        .wdata_i   (wdata),
        .cnt_o     (cnt[g]),
        .base_o    (base[g]),
        .inh_o     (inh[g]),
        .ctrl_o    (ctrl[g]),
        .roll_o    (roll[g])
      );

      // R9: every pulse follows a rollover on the clock before
      a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq_q[g] |-> $past(roll[g]));
      // R9: pulses last one clock (no rollover can repeat within one tick)
      if (DIV > 1) begin : g_pulse
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
          irq_q[g] |=> !irq_q[g]);
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (int'(idx) < NUM_TMR) begin
      unique case (fld)
        FLD_BASE: begin
          rd_next[CNT_W-1:0] = base[idx];
          rd_next[DATA_W-1]  = inh[idx];
        end
        FLD_COUNT: rd_next[CNT_W-1:0] = cnt[idx];
        FLD_CTRL:  rd_next[1:0] = ctrl[idx];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      irq_q   <= roll & ~fwd;
      rdata_q <= rd_next;
    end
  end

  assign irq   = irq_q;
  assign rdata = rdata_q;
endmodule

// File: tb/prescaled_timer_bank_bench.sv
module prescaled_timer_bank_bench;
  localparam int NT   = 4;
  localparam int CW   = 12;
  localparam int DIVB = 8;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  prescaled_timer_bank u_prescaled_timer_bank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  int          m_pre;
  int          m_base[NT], m_inh[NT], m_wrap[NT], m_casc[NT], m_cnt[NT];
  logic [3:0]  m_irq;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    int  i_sel, f_sel;
    bit  tk;
    bit  rl[NT];
    bit  ev[NT];
    cyc++;
    if (rst) begin
      m_pre = 0; m_irq = '0; m_rd = '0;
      for (int i = 0; i < NT; i++) begin
        m_base[i] = 0; m_inh[i] = 1; m_wrap[i] = 0; m_casc[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      i_sel = int'(addr) / 4;
      f_sel = int'(addr) % 4;
      tk = (m_pre == DIVB - 1);
      for (int i = 0; i < NT; i++) begin
        ev[i] = (i > 0 && m_casc[i] != 0) ? rl[i-1] : tk;
        rl[i] = ev[i] && m_inh[i] == 0 && m_cnt[i] == 0;
      end
      for (int i = 0; i < NT; i++)
        m_irq[i] = rl[i] && !(i < NT - 1 && m_casc[i+1] != 0);
      case (f_sel)
        0: m_rd = (32'(m_inh[i_sel]) << 31) | 32'(m_base[i_sel]);
        1: m_rd = 32'(m_cnt[i_sel]);
        2: m_rd = 32'(m_casc[i_sel] * 2 + m_wrap[i_sel]);
        default: m_rd = '0;
      endcase
      for (int i = 0; i < NT; i++) begin
        if (we && f_sel == 0 && i_sel == i && m_inh[i] != 0 && !wdata[31])
          m_cnt[i] = int'(wdata) & MASK;
        else if (ev[i] && m_inh[i] == 0)
          m_cnt[i] = (m_cnt[i] == 0) ? (m_wrap[i] != 0 ? MASK : m_base[i]) : m_cnt[i] - 1;
      end
      if (we && f_sel == 0) begin
        m_base[i_sel] = int'(wdata) & MASK;
        m_inh[i_sel]  = int'(wdata[31]);
      end
      if (we && f_sel == 2) begin
        m_wrap[i_sel] = int'(wdata[0]);
        m_casc[i_sel] = int'(wdata[1]);
      end
      m_pre = (m_pre + 1) % DIVB;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison with the model (R9 timing of irq, R2 read path)
  always @(negedge clk) begin
    if (!rst) begin
      check("R9 model irq", 32'(irq), 32'(m_irq));
      check("R2 model rdata", rdata, m_rd);
    end
  end

  function automatic logic [3:0] ad(int t, int f);
    return 4'(t * 4 + f);
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_irq(int t, int limit, output int when);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!irq[t] && n < limit);
    if (!irq[t]) check("irq timeout", 32'(0), 32'(1));
    when = cyc;
  endtask

  task automatic arm(int t, int base);
    wr(ad(t, 0), 32'h8000_0000 | 32'(base));
    wr(ad(t, 0), 32'(base));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, v2;
    int ta, tb, tc, cnt2, prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq", 32'(irq), 32'(0));
    check("R11 rdata", rdata, 32'(0));
    for (int t = 0; t < NT; t++) begin
      rd(ad(t, 0), v); check("R11 base/inhibit", v, 32'h8000_0000);
      rd(ad(t, 1), v); check("R11 count", v, 32'(0));
      rd(ad(t, 2), v); check("R11 ctrl", v, 32'(0));
    end

    // R1/R3: base 0 -> every 8 clocks
    arm(0, 0);
    wait_irq(0, 100, ta); wait_irq(0, 100, tb);
    check("R1 R3 base0 period", 32'(tb - ta), 32'(8));
    // R3/R9: base 1 -> 16, one-clock pulse
    arm(0, 1);
    wait_irq(0, 100, ta);
    @(negedge clk); check("R9 pulse width", 32'(irq[0]), 32'(0));
    wait_irq(0, 100, tb);
    check("R3 base1 period", 32'(tb - ta), 32'(16));
    // R3/R4: base 10 -> 88, repeated through reload
    arm(0, 10);
    wait_irq(0, 200, ta); wait_irq(0, 200, tb); wait_irq(0, 200, tc);
    check("R3 base10 period", 32'(tb - ta), 32'(88));
    check("R4 reload period", 32'(tc - tb), 32'(88));

    // R2: arm timer1 with 20, observe downward steps of one
    arm(1, 20);
    @(negedge clk); addr = ad(1, 1);
    @(negedge clk); prev = int'(rdata);
    check("R2 first value", 32'(prev == 20 || prev == 19), 32'(1));
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (int'(rdata) != prev) begin
        check("R2 step by one", rdata, 32'(prev - 1));
        prev = int'(rdata);
      end
    end

    // R6: inhibit holds count and silences irq
    wr(ad(1, 0), 32'h8000_0000 | 32'd20);
    rd(ad(1, 1), v1);
    cnt2 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); if (irq[1]) cnt2++;
    end
    rd(ad(1, 1), v2);
    check("R6 count held", v2, v1);
    check("R6 no irq", 32'(cnt2), 32'(0));

    // R10: count field ignores writes
    wr(ad(1, 1), 32'h0000_0ABC);
    rd(ad(1, 1), v);
    check("R10 count read-only", v, v1);

    // R7: base rewrite while running
    arm(0, 3);
    wait_irq(0, 100, ta);
    repeat (5) @(negedge clk);
    wr(ad(0, 0), 32'd7);
    wait_irq(0, 100, tb); wait_irq(0, 200, tc);
    check("R7 current period kept", 32'(tb - ta), 32'(32));
    check("R7 new base at reload", 32'(tc - tb), 32'(64));

    // R8: cascade on timer0 has no effect
    wr(ad(0, 2), 32'd2);
    arm(0, 0);
    wait_irq(0, 100, ta); wait_irq(0, 100, tb);
    check("R8 timer0 cascade ignored", 32'(tb - ta), 32'(8));
    wr(ad(0, 0), 32'h8000_0000);
    wr(ad(0, 2), 32'd0);

    // R8: timer3 cascaded from timer2
    wr(ad(3, 2), 32'd2);
    arm(3, 2);
    arm(2, 1);
    cnt2 = 0;
    wait_irq(3, 200, ta); wait_irq(3, 200, tb);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); if (irq[2]) cnt2++;
    end
    check("R8 chained period", 32'(tb - ta), 32'(48));
    check("R8 upstream silent", 32'(cnt2), 32'(0));
    wr(ad(2, 0), 32'h8000_0000);

    // R5: wrap mode
    wr(ad(1, 2), 32'd1);
    arm(1, 2);
    wait_irq(1, 100, ta);
    wait_irq(1, 40000, tb);
    check("R5 wrap interval", 32'(tb - ta), 32'(32768));

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule